// File: doc/BRIEF.md
# Ratio-Clocked Synchronous CDC FIFO

This FIFO moves data words from a write clock domain to a read clock domain when the two clocks are related by an integer frequency multiple and their rising edges line up. One clock is the base clock. The other runs N times faster and has a rising edge on every base edge. Because the timing relation is known, neither side needs gray-coded pointers or synchroniser stages. Each side keeps a binary pointer. The slower side reads the faster side's pointer as it stood at the last shared edge, and the faster side reads the slower side's pointer directly, because that pointer only moves on shared edges.

The faster side counts its own cycles modulo N. It republishes its pointer only in the cycle that closes on a shared edge. Every flag that the slower side sees therefore moves only on the slower clock. A side's view of the other pointer can lag the true value but is never ahead of it, so full and empty are conservative on both sides. Set one of the two frequency parameters to N and the other to 1. With both at 1 the block is an ordinary single-clock FIFO.

The read port is first-word-fall-through. Reset is asynchronous and active low. When N is greater than 1, deassert reset inside the first fast cycle that follows a shared rising edge, so that the fast side's phase count starts aligned to that edge.

Top module: `ratio_cdc_fifo`

## Requirements
- R1: While reset is low and just after it is released, wr_full_o and rd_full_o are 0 and wr_empty_o and rd_empty_o are 1. All flags are active high.
- R2: Words leave in the order they were accepted, with none lost and none repeated, at write:read frequency ratios of 1:1, 1:3 and 3:1. Whenever rd_empty_o is 0, rd_data_o shows the oldest unread word, and a rising read clock edge with rd_en_i high consumes it.
- R3: A write attempted while wr_full_o is 1 has no effect. The stored words and their order stay unchanged, and no extra word can be read later.
- R4: A read attempted while rd_empty_o is 1 has no effect. The next word written is the next word read.
- R5: The FIFO holds DEPTH words. With no reads, wr_full_o is 0 for the first DEPTH accepted writes and 1 after them. rd_full_o is 1 once the read side has passed the next shared edge.
- R6: The flags of whichever side runs on the slower clock change only at rising edges of that slower clock.
- R7: A write or read done on one side appears in the other side's flags after the first shared rising edge at or after it, and not before that edge.
- R8: With both frequency parameters at 1, a write clears rd_empty_o right after the same edge, and a read of the last word sets wr_empty_o right after the same edge.
- R9: Pulling rst_ni low between clock edges immediately empties the FIFO: both empty flags go to 1 and both full flags go to 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr_i | input | 1 | Write-side clock, rising edge |
| clk_rd_i | input | 1 | Read-side clock, rising edge, edge-aligned with clk_wr_i |
| rst_ni | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to write |
| wr_full_o | output | 1 | Write-side view: no free slot |
| wr_empty_o | output | 1 | Write-side view: nothing stored |
| rd_en_i | input | 1 | Read request; consumes the word on rd_data_o |
| rd_data_o | output | DATA_W | Oldest unread word |
| rd_full_o | output | 1 | Read-side view: all slots used |
| rd_empty_o | output | 1 | Read-side view: nothing to read |

## Verification
The hardest case to reach is a fast-side pointer change that lands in a non-final phase, so that its effect on the slow side has to wait for the next shared edge. The stimulus syncs to a shared edge and issues the single write or read one fast cycle later. It then samples the slow side's flag once before the boundary and once after it. Full is reached by filling with the reader held off and then adding extra writes. Random traffic does the rest, with a reader that is slow for the first half and eager for the second, so the FIFO is driven both full and empty. A separate monitor checks that the slow side's flags hold still at every fast edge between shared edges.

// File: rtl/ratio_cdc_pkg.sv
package ratio_cdc_pkg;

  typedef enum logic {
    SIDE_WR = 1'b0,
    SIDE_RD = 1'b1
  } side_e;

  function automatic int unsigned phase_bits(int unsigned mult);
    return (mult > 1) ? $clog2(mult) : 1;
  endfunction

endpackage

// File: rtl/ratio_cdc_mem.sv
module ratio_cdc_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ratio_cdc_side.sv
module ratio_cdc_side
  import ratio_cdc_pkg::*;
#(
  parameter side_e       SIDE  = SIDE_WR,
  parameter int unsigned MULT  = 1,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [PW-1:0] peer_ptr_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] pub_o,
  output logic          fire_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [PW-1:0] ptr_q, ptr_d, level;
  logic          blocked;

  // occupancy as seen from this side; the peer view may lag, never lead
  assign level   = (SIDE == SIDE_WR) ? (ptr_q - peer_ptr_i) : (peer_ptr_i - ptr_q);
  assign full_o  = (level == PW'(DEPTH));
  assign empty_o = (level == '0);
  assign blocked = (SIDE == SIDE_WR) ? full_o : empty_o;
  assign fire_o  = req_i & ~blocked;
  assign ptr_d   = ptr_q + PW'(fire_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  generate
    if (MULT > 1) begin : g_fast
      localparam int unsigned CW = phase_bits(MULT);
      logic [CW-1:0] phase_q;
      logic [PW-1:0] pub_q;
      logic          last;

      // last = this fast cycle closes on a shared rising edge
      assign last = (phase_q == CW'(MULT - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   phase_q <= '0;
        else if (last) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pub_q <= '0;
        else if (last) pub_q <= ptr_d;
      end

      assign pub_o = pub_q;

      assert_pub_at_boundary_R6: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !last |=> $stable(pub_o));
    end else begin : g_slow
      assign pub_o = ptr_q;
    end
  endgenerate

  assert_level_bounded_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    level <= PW'(DEPTH));

  assert_blocked_hold_R3_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (req_i && blocked) |=> (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/ratio_cdc_fifo.sv
module ratio_cdc_fifo
  import ratio_cdc_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DEPTH        = 8,
  parameter int unsigned WR_FREQ_MULT = 1,
  parameter int unsigned RD_FREQ_MULT = 1
) (
  input  logic              clk_wr_i,
  input  logic              clk_rd_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  output logic              wr_empty_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_full_o,
  output logic              rd_empty_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wr_ptr, wr_pub, rd_ptr, rd_pub;
  logic          wr_fire, rd_fire;
  logic [PW-1:0] true_level, rd_seen_level, wr_seen_level;

  ratio_cdc_side #(
    .SIDE (SIDE_WR),
    .MULT (WR_FREQ_MULT),
    .DEPTH(DEPTH)
  ) u_wr_side (
    .clk_i     (clk_wr_i),
    .rst_ni    (rst_ni),
    .req_i     (wr_en_i),
    .peer_ptr_i(rd_pub),
    .ptr_o     (wr_ptr),
    .pub_o     (wr_pub),
    .fire_o    (wr_fire),
    .full_o    (wr_full_o),
    .empty_o   (wr_empty_o)
  );

  ratio_cdc_side #(
    .SIDE (SIDE_RD),
    .MULT (RD_FREQ_MULT),
    .DEPTH(DEPTH)
  ) u_rd_side (
    .clk_i     (clk_rd_i),
    .rst_ni    (rst_ni),
    .req_i     (rd_en_i),
    .peer_ptr_i(wr_pub),
    .ptr_o     (rd_ptr),
    .pub_o     (rd_pub),
    .fire_o    (rd_fire),
    .full_o    (rd_full_o),
    .empty_o   (rd_empty_o)
  );

  ratio_cdc_mem #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_mem (
    .clk_i  (clk_wr_i),
    .we_i   (wr_fire),
    .waddr_i(wr_ptr[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr[AW-1:0]),
    .rdata_o(rd_data_o)
  );

  assign true_level    = wr_ptr - rd_ptr;
  assign rd_seen_level = wr_pub - rd_ptr;
  assign wr_seen_level = wr_ptr - rd_pub;

  assert_rd_view_conservative_R2: assert property (
    @(posedge clk_rd_i) disable iff (!rst_ni)
    rd_seen_level <= true_level);

  assert_wr_view_conservative_R3: assert property (
    @(posedge clk_wr_i) disable iff (!rst_ni)
    wr_seen_level >= true_level);

  assert_pop_only_stored_R4: assert property (
    @(posedge clk_rd_i) disable iff (!rst_ni)
    rd_fire |-> (wr_ptr != rd_ptr));

endmodule

// File: tb/cdc_lane.sv
module cdc_lane #(
  parameter int unsigned WR_MULT = 1,
  parameter int unsigned RD_MULT = 1,
  parameter string       TAG     = "1:1"
) (
  input logic clk_fast_i,
  input logic clk_slow_i
);

  localparam int unsigned DEPTH  = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned N_RAND = 240;

  logic              clk_wr, clk_rd, rst_n;
  logic              wr_en, rd_en;
  logic              wr_full, wr_empty, rd_full, rd_empty;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign clk_wr = (WR_MULT >= RD_MULT) ? clk_fast_i : clk_slow_i;
  assign clk_rd = (RD_MULT >= WR_MULT) ? clk_fast_i : clk_slow_i;

  ratio_cdc_fifo #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .WR_FREQ_MULT(WR_MULT),
    .RD_FREQ_MULT(RD_MULT)
  ) i_ratio_cdc_fifo (
    .clk_wr_i  (clk_wr),
    .clk_rd_i  (clk_rd),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .wr_full_o (wr_full),
    .wr_empty_o(wr_empty),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .rd_full_o (rd_full),
    .rd_empty_o(rd_empty)
  );

  int                n_checks = 0;
  int                n_fails  = 0;
  bit                done     = 0;
  bit                mon_on   = 0;
  bit                wr_done  = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [1:0]        slow_flags, slow_seen;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, TAG, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [DATA_W-1:0] d);
    @(negedge clk_wr);
    wr_en   = 1'b1;
    wr_data = d;
    if (!wr_full) exp_q.push_back(d);
    @(posedge clk_wr);
    #1 wr_en = 1'b0;
  endtask

  task automatic take_word(input string req);
    @(negedge clk_rd);
    rd_en = 1'b1;
    if (!rd_empty) begin
      if (exp_q.size() == 0) chk(req, "word shown with none outstanding", 1, 0);
      else begin
        chk(req, "head word", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    @(posedge clk_rd);
    #1 rd_en = 1'b0;
  endtask

  // R6: flags of the slower side hold between slow edges
  assign slow_flags = (WR_MULT > 1) ? {rd_full, rd_empty} : {wr_full, wr_empty};

  always @(posedge clk_slow_i) begin
    #1 slow_seen = slow_flags;
  end

  always @(negedge clk_fast_i) begin
    if (WR_MULT != RD_MULT && mon_on && rst_n)
      chk("R6", "slow-side flags moved between slow edges", slow_flags, slow_seen);
  end

  initial begin
    wr_en = 0; rd_en = 0; wr_data = '0; rst_n = 0;
    @(posedge clk_slow_i);
    #1 rst_n = 1;

    chk("R1", "wr_full after reset", wr_full, 0);
    chk("R1", "wr_empty after reset", wr_empty, 1);
    chk("R1", "rd_full after reset", rd_full, 0);
    chk("R1", "rd_empty after reset", rd_empty, 1);
    mon_on = 1;

    repeat (3) take_word("R4");
    chk("R4", "still empty after reads on empty", rd_empty, 1);

    // write one word one fast cycle after a shared edge (or on it, if the writer is slow)
    @(posedge clk_slow_i);
    put_word(16'hA5A5);
    if (WR_MULT > 1) begin
      chk("R7", "read side empty before boundary", rd_empty, 1);
      @(posedge clk_rd);
      #1 chk("R7", "read side sees word after boundary", rd_empty, 0);
    end else begin
      chk((WR_MULT == RD_MULT) ? "R8" : "R7", "read side sees word at once", rd_empty, 0);
    end

    @(posedge clk_slow_i);
    take_word("R4");
    if (RD_MULT > 1) begin
      chk("R7", "write side still holds word before boundary", wr_empty, 0);
      @(posedge clk_wr);
      #1 chk("R7", "write side sees free slot after boundary", wr_empty, 1);
    end else begin
      chk((WR_MULT == RD_MULT) ? "R8" : "R7", "write side empty at once", wr_empty, 1);
    end

    // fill with no reads, then push past full
    @(negedge clk_wr);
    for (int i = 0; i < DEPTH + 3; i++) begin
      chk("R5", "write full vs stored count", wr_full, (i >= DEPTH) ? 1 : 0);
      wr_en   = 1'b1;
      wr_data = (i < DEPTH) ? DATA_W'(16'h0100 + i) : DATA_W'(16'hDEAD);
      if (!wr_full) exp_q.push_back(wr_data);
      @(negedge clk_wr);
    end
    wr_en = 1'b0;
    repeat (2) @(posedge clk_slow_i);
    #1 chk("R5", "read side full", rd_full, 1);

    repeat (DEPTH) take_word("R3");
    repeat (2) @(posedge clk_slow_i);
    #1;
    chk("R3", "no extra word after drain", rd_empty, 1);
    chk("R3", "model drained", exp_q.size(), 0);

    fork
      begin : writer
        int sent;
        sent = 0;
        while (sent < N_RAND) begin
          @(negedge clk_wr);
          wr_en   = ($urandom_range(0, 99) < 60);
          wr_data = DATA_W'(16'h4000 + sent);
          if (wr_en && !wr_full) begin
            exp_q.push_back(wr_data);
            sent++;
          end
        end
        @(negedge clk_wr);
        wr_en   = 1'b0;
        wr_done = 1;
      end
      begin : reader
        int got;
        got = 0;
        while (!(wr_done && exp_q.size() == 0)) begin
          @(negedge clk_rd);
          rd_en = ($urandom_range(0, 99) < ((got < N_RAND / 2) ? 30 : 85));
          if (!rd_empty) begin
            if (exp_q.size() == 0) chk("R2", "word shown with none outstanding", 1, 0);
            else begin
              chk("R2", "head word in order", rd_data, exp_q[0]);
              if (rd_en) begin
                void'(exp_q.pop_front());
                got++;
              end
            end
          end
        end
        @(negedge clk_rd);
        rd_en = 1'b0;
      end
    join

    repeat (3) @(posedge clk_slow_i);
    #1;
    chk("R2", "read side empty at end", rd_empty, 1);
    chk("R2", "write side empty at end", wr_empty, 1);
    chk("R2", "model empty at end", exp_q.size(), 0);

    put_word(16'h7777);
    put_word(16'h7778);
    repeat (2) @(posedge clk_slow_i);
    #3 mon_on = 0;
    #4 rst_n = 0;
    #1;
    chk("R9", "rd_empty on async reset", rd_empty, 1);
    chk("R9", "wr_empty on async reset", wr_empty, 1);
    chk("R9", "wr_full on async reset", wr_full, 0);
    chk("R9", "rd_full on async reset", rd_full, 0);
    exp_q.delete();
    done = 1;
  end

endmodule

// File: tb/test_ratio_cdc_fifo.sv
module test_ratio_cdc_fifo;

  localparam int          CLK_PERIOD = 10;
  localparam int unsigned RATIO      = 3;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  int   ph;
  bit   timed_out;
  int   total_checks, total_fails;

  // both clocks from one process so shared edges fall in the same time step
  initial begin
    ph = 0;
    forever begin
      #(CLK_PERIOD / 2);
      clk_fast = ~clk_fast;
      ph++;
      if (ph % RATIO == 0) clk_slow = ~clk_slow;
    end
  end

  cdc_lane #(.WR_MULT(1), .RD_MULT(1), .TAG("1:1")) u_lane_11 (
    .clk_fast_i(clk_fast), .clk_slow_i(clk_fast));

  cdc_lane #(.WR_MULT(1), .RD_MULT(RATIO), .TAG("1:3")) u_lane_13 (
    .clk_fast_i(clk_fast), .clk_slow_i(clk_slow));

  cdc_lane #(.WR_MULT(RATIO), .RD_MULT(1), .TAG("3:1")) u_lane_31 (
    .clk_fast_i(clk_fast), .clk_slow_i(clk_slow));

  initial begin
    timed_out = 0;
    fork
      wait (u_lane_11.done && u_lane_13.done && u_lane_31.done);
      begin
        #(CLK_PERIOD * 100000);
        timed_out = 1;
      end
    join_any
    total_checks = u_lane_11.n_checks + u_lane_13.n_checks + u_lane_31.n_checks;
    total_fails  = u_lane_11.n_fails + u_lane_13.n_fails + u_lane_31.n_fails;
    if (timed_out) begin
      total_checks++;
      total_fails++;
      $display("FAIL watchdog R2: actual=hung expected=all lanes done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", total_checks, total_fails);
    $finish;
  end

endmodule